// File: doc/BRIEF.md
# Two-Phase Address DRAM Array Controller

This block turns flat supercell requests from a host into the two-step addressing sequence of a small dynamic memory array, and it includes a synthesizable model of that array. The array is a square grid of supercells. The host gives a single index. The controller sends the upper half of the index as a row address, then sends the lower half as a column address over the same narrow bus. A separate strobe qualifies each of the two phases.

Each array copies the whole selected row into a private row buffer when the row phase ends. The column phase then reads one supercell out of that buffer, or overwrites one supercell in it. On a write, the buffer is copied back into the array row before the controller returns to idle. Several byte-wide arrays share the address bus and strobes. Together they form one wide word, with each array owning a fixed byte lane.

Top module: `dram_mux_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `req_ready` is 1, `mem_row_stb`, `mem_col_stb` and `rsp_valid` are 0, and `mem_addr` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. For the next ROW_CYC cycles, `mem_row_stb` is 1 and `mem_addr` carries the upper ROW_W bits of `req_idx`.
- R3: Directly after the row phase, `mem_col_stb` is 1 for COL_CYC cycles and `mem_addr` carries the lower COL_W bits of the index. The two strobes are never 1 in the same cycle, and the column phase is never entered without a row phase immediately before it.
- R4: After the column phase come XFER_CYC cycles with both strobes 0 and `mem_addr` 0. `req_ready` is 0 from the acceptance edge until these cycles are over.
- R5: A read (`req_we`=0) raises `rsp_valid` for exactly one cycle, in the first cycle after the transfer phase. In that cycle `rsp_rdata` holds the word most recently written to that index.
- R6: A write (`req_we`=1) stores `req_wdata` at the index. The other supercells of the same row keep their values, because the row buffer is written back whole.
- R7: Lane k of the word (bits 8k+7 down to 8k) is stored and returned only by byte array k. Distinct bytes in every lane come back unmixed.
- R8: A new request presented in the response cycle is accepted at once, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_we | input | 1 | 1 = write, 0 = read |
| req_idx | input | IDX_W (4) | Flat supercell index |
| req_wdata | input | LANES*LANE_W (64) | Write word |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | LANES*LANE_W (64) | Read word |
| mem_addr | output | IDX_W/2 (2) | Shared row/column address bus |
| mem_row_stb | output | 1 | Row phase strobe |
| mem_col_stb | output | 1 | Column phase strobe |

## Verification
The hardest case to reach is a write that changes one supercell while leaving its row neighbours intact. This is only visible if the neighbours already hold distinct known data, and are read back after the whole-row write-back. The stimulus therefore first fills every supercell with a unique byte per lane. It then reads all cells in a shuffled order, overwrites one cell in a middle row, and reads that entire row again. Back-to-back requests issued in the response cycle cover the turnaround. A behavioural per-cycle model checks the row-then-column order on the bus in every cycle.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ROW  = 2'd1,
    PH_COL  = 2'd2,
    PH_XFER = 2'd3
  } phase_e;
endpackage

// File: rtl/dram_byte_array.sv
module dram_byte_array #(
  parameter int AW = 2,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          row_load,
  input  logic          col_hit,
  input  logic          row_store,
  input  logic          wr,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);
  localparam int ROWS  = 1 << AW;
  localparam int COLS  = 1 << AW;
  localparam int ROWBW = COLS * W;

  logic [ROWBW-1:0] cells_q [ROWS];
  logic [ROWBW-1:0] rbuf_q, rbuf_d;
  logic [AW-1:0]    open_row_q;
  logic [W-1:0]     dout_q, dout_d;

  always_comb begin
    rbuf_d = rbuf_q;
    dout_d = dout_q;
    if (row_load) begin
      rbuf_d = cells_q[addr];
    end else if (col_hit) begin
      if (wr) rbuf_d[addr*W +: W] = din;
      else    dout_d = rbuf_q[addr*W +: W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf_q     <= '0;
      open_row_q <= '0;
      dout_q     <= '0;
    end else begin
      if (row_load || col_hit) rbuf_q <= rbuf_d;
      if (col_hit && !wr)      dout_q <= dout_d;
      if (row_load)            open_row_q <= addr;
    end
  end

  always_ff @(posedge clk) begin
    if (row_store) cells_q[open_row_q] <= rbuf_q;
  end

  assign dout = dout_q;

  a_r2_row_latched: assert property (@(posedge clk) disable iff (!rst_n)
    row_load |=> (open_row_q == $past(addr)));
  a_r6_one_phase_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_load && col_hit));
endmodule

// File: rtl/dram_phase_seq.sv
module dram_phase_seq
  import dram_ctl_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int ROW_CYC  = 2,
  parameter int COL_CYC  = 2,
  parameter int XFER_CYC = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_we,
  input  logic [IDX_W-1:0]     req_idx,
  output logic                 req_ready,
  output logic                 accept,
  output logic                 wr_q,
  output logic [IDX_W/2-1:0]   bus_addr,
  output logic                 row_stb,
  output logic                 col_stb,
  output logic                 row_load,
  output logic                 col_hit,
  output logic                 row_store,
  output logic                 rsp_valid
);
  localparam int ROW_W = IDX_W / 2;
  localparam int COL_W = IDX_W - ROW_W;
  localparam int MAXC  = (ROW_CYC > COL_CYC) ?
                         ((ROW_CYC > XFER_CYC) ? ROW_CYC : XFER_CYC) :
                         ((COL_CYC > XFER_CYC) ? COL_CYC : XFER_CYC);
  localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q;
  logic              rsp_q, rsp_d;
  logic              last;
  int                lim;

  always_comb begin
    case (ph_q)
      PH_ROW:  lim = ROW_CYC;
      PH_COL:  lim = COL_CYC;
      PH_XFER: lim = XFER_CYC;
      default: lim = 1;
    endcase
    last = (cnt_q == CNT_W'(lim - 1));
  end

  assign req_ready = (ph_q == PH_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    rsp_d = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (accept) begin
          ph_d  = PH_ROW;
          cnt_d = '0;
        end
      end
      PH_ROW: begin
        if (last) begin ph_d = PH_COL; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      PH_COL: begin
        if (last) begin ph_d = PH_XFER; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      default: begin
        if (last) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
          rsp_d = !wr_q;
        end else cnt_d = cnt_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      rsp_q <= 1'b0;
      idx_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      rsp_q <= rsp_d;
      if (accept) begin
        idx_q <= req_idx;
        wr_q  <= req_we;
      end
    end
  end

  always_comb begin
    case (ph_q)
      PH_ROW:  bus_addr = idx_q[IDX_W-1 -: ROW_W];
      PH_COL:  bus_addr = idx_q[COL_W-1:0];
      default: bus_addr = '0;
    endcase
  end

  assign row_stb   = (ph_q == PH_ROW);
  assign col_stb   = (ph_q == PH_COL);
  assign row_load  = row_stb && last;
  assign col_hit   = col_stb && last;
  assign row_store = (ph_q == PH_XFER) && last && wr_q;
  assign rsp_valid = rsp_q;

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_stb && col_stb));
  a_r3_col_after_row: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_stb) |-> $past(row_stb));
  a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (row_stb || col_stb) |-> !req_ready);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r2_row_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (row_stb && $past(row_stb)) |-> $stable(bus_addr));
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int LANES    = 8,
  parameter int LANE_W   = 8,
  parameter int IDX_W    = 4,
  parameter int ROW_CYC  = 2,
  parameter int COL_CYC  = 2,
  parameter int XFER_CYC = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_we,
  input  logic [IDX_W-1:0]          req_idx,
  input  logic [LANES*LANE_W-1:0]   req_wdata,
  output logic                      rsp_valid,
  output logic [LANES*LANE_W-1:0]   rsp_rdata,
  output logic [IDX_W/2-1:0]        mem_addr,
  output logic                      mem_row_stb,
  output logic                      mem_col_stb
);
  localparam int AW     = IDX_W / 2;
  localparam int WORD_W = LANES * LANE_W;

  logic              accept, wr_q, row_load, col_hit, row_store;
  logic [WORD_W-1:0] wdata_q;

  dram_phase_seq #(
    .IDX_W(IDX_W), .ROW_CYC(ROW_CYC), .COL_CYC(COL_CYC), .XFER_CYC(XFER_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_we(req_we), .req_idx(req_idx),
    .req_ready(req_ready), .accept(accept), .wr_q(wr_q),
    .bus_addr(mem_addr), .row_stb(mem_row_stb), .col_stb(mem_col_stb),
    .row_load(row_load), .col_hit(col_hit), .row_store(row_store),
    .rsp_valid(rsp_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wdata_q <= '0;
    else if (accept) wdata_q <= req_wdata;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    dram_byte_array #(.AW(AW), .W(LANE_W)) u_arr (
      .clk(clk), .rst_n(rst_n), .addr(mem_addr),
      .row_load(row_load), .col_hit(col_hit), .row_store(row_store),
      .wr(wr_q), .din(wdata_q[k*LANE_W +: LANE_W]),
      .dout(rsp_rdata[k*LANE_W +: LANE_W])
    );
  end

  a_r4_idle_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_row_stb && !mem_col_stb) |-> (mem_addr == '0));
endmodule

// File: tb/dram_mux_ctrl_tb.sv
`timescale 1ns/1ps
module dram_mux_ctrl_tb;
  localparam int IDX_W = 4;
  localparam int RW    = IDX_W / 2;
  localparam int NCELL = 1 << IDX_W;
  localparam int RC = 2, CC = 2, XC = 1;
  localparam int TOT = RC + CC + XC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [IDX_W-1:0] req_idx = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_row_stb, mem_col_stb;
  logic [63:0] rsp_rdata;
  logic [RW-1:0] mem_addr;

  always #2 clk = ~clk;

  dram_mux_ctrl #(.LANES(8), .LANE_W(8), .IDX_W(IDX_W),
    .ROW_CYC(RC), .COL_CYC(CC), .XFER_CYC(XC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_idx(req_idx), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_row_stb(mem_row_stb), .mem_col_stb(mem_col_stb));

  int checks = 0, errors = 0;
  logic [63:0] mdl [NCELL];
  bit   mon_en = 0;
  int   t = 0;
  logic cur_we;
  logic [IDX_W-1:0] cur_idx;
  logic [63:0] cur_exp;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0d", tag, act, exp, t);
    end
  endtask

  always @(negedge clk) if (mon_en) begin
    logic er, ec, ey;
    logic [RW-1:0] ea;
    er = (t >= 1 && t <= RC);
    ec = (t > RC && t <= RC + CC);
    ey = (t == 0 || t == TOT + 1);
    ea = er ? cur_idx[IDX_W-1 -: RW] : (ec ? cur_idx[RW-1:0] : '0);
    chk("R2 row strobe", 64'(mem_row_stb), 64'(er));
    chk("R3 col strobe", 64'(mem_col_stb), 64'(ec));
    chk("R2/R3 addr bus row then col", 64'(mem_addr), 64'(ea));
    chk("R4 ready", 64'(req_ready), 64'(ey));
    chk("R5 rsp_valid", 64'(rsp_valid), 64'(t == TOT + 1 && !cur_we));
    if (t == TOT + 1 && !cur_we) chk("R5/R6/R7 read data", rsp_rdata, cur_exp);
    if (ey) begin
      if (req_valid) begin
        t = 1; cur_we = req_we; cur_idx = req_idx;
        if (req_we) mdl[req_idx] = req_wdata;
        else cur_exp = mdl[req_idx];
      end else t = 0;
    end else t++;
  end

  // called at posedge+1 with controller idle; returns at posedge+1 of response cycle
  task automatic send(logic we, int idx, logic [63:0] d);
    req_valid = 1'b1; req_we = we; req_idx = IDX_W'(idx); req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_wdata = '0;
    repeat (TOT) @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] pat(int i);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = 8'((i << 4) | k) ^ 8'h5C;
    return v;
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int ord [NCELL];
    repeat (2) @(negedge clk);
    // R1 during reset
    chk("R1 ready in reset", 64'(req_ready), 64'd1);
    chk("R1 row strobe in reset", 64'(mem_row_stb), 64'd0);
    chk("R1 col strobe in reset", 64'(mem_col_stb), 64'd0);
    chk("R1 rsp in reset", 64'(rsp_valid), 64'd0);
    chk("R1 addr in reset", 64'(mem_addr), 64'd0);
    @(posedge clk); #1 rst_n = 1'b1; mon_en = 1;
    repeat (2) @(posedge clk); #1;
    // R6/R7: fill every supercell, distinct byte per lane, back to back (R8)
    for (int i = 0; i < NCELL; i++) send(1'b1, i, pat(i));
    // random read order, occasional gaps
    for (int i = 0; i < NCELL; i++) ord[i] = i;
    for (int i = NCELL - 1; i > 0; i--) begin
      int j, tmp;
      j = $urandom_range(i, 0);
      tmp = ord[i]; ord[i] = ord[j]; ord[j] = tmp;
    end
    for (int i = 0; i < NCELL; i++) begin
      send(1'b0, ord[i], '0);
      if (i % 3 == 2) begin repeat (2) @(posedge clk); #1; end
    end
    // R6: overwrite one cell in row 1, whole row read back
    send(1'b1, 6, 64'hA5A5_0F0F_3C3C_9696);
    for (int c = 4; c < 8; c++) send(1'b0, c, '0);
    // R8: write then read same index with no idle cycle
    send(1'b1, 15, 64'h0123_4567_89AB_CDEF);
    send(1'b0, 15, '0);
    send(1'b0, 0, '0);
    repeat (4) @(posedge clk); #1;
    finish_run();
  end
endmodule